// File: doc/BRIEF.md
# Banked subsystem memory decoder

This block sits in front of the memories of a display sub-processor. It decodes the upper quarter of the sub-processor's 16-bit address space. The decode depends on a small set of control registers. The result is a one-hot region select plus a byte offset into the selected memory. The possible targets are:

- character-generator ROM or character RAM;
- one of four system ROM banks;
- a monitor RAM;
- a banked console RAM.

The decode also produces read and write enables. A write-protect setting gates writes to the character RAM and the monitor RAM. Reads from an address that maps to nothing raise a flag, and the data path uses that flag to return 0xFF.

The ROM bank and the monitor-RAM request are held in two places. A register takes software writes. A separate in-use copy is what the decoder actually uses. The in-use copy is loaded only when the sub-processor is restarted, either by reset or by release from halt. This lets the main processor prepare a new memory map without disturbing the running code. The mode register drives its line-mode and protect outputs from active-low fields. The mode register also carries flags that neighbouring logic consumes.

Top module: `subsys_mem_decoder`

## Requirements
- R1: After reset the decoder uses ROM bank 0 and character ROM bank 0, with monitor RAM not in use. At the outputs, write protect is on and the 400-line, 256k-colour and both kanji flags are low. The character RAM bank and console bank are 0.
- R2: For addresses 0xD800–0xDFFF with monitor RAM not in use, the region is character ROM with offset = crom_bank*0x800 + (addr−0xD800). The character ROM bank is written through select 1, bits 1:0.
- R3: With monitor RAM in use, addresses 0xE000–0xFFFF select monitor RAM at offset addr−0xE000. Addresses 0xD800–0xDFFF select character RAM at offset cram_bank*0x800 + (addr−0xD800).
- R4: With monitor RAM not in use, 0xE000–0xFFFF maps by the in-use ROM bank, as follows:
  - bank 0 selects ROM C with offset addr−0xD800;
  - bank 1 selects ROM A with offset addr−0xE000;
  - bank 2 selects ROM B with offset addr−0xE000;
  - bank 3 selects character ROM with offset addr−0xE000.
- R5: The bank register is written through select 2. Its fields are:
  - bits 2:0 are the character RAM bank;
  - bits 4:3 are the console bank, and the value 3 is stored as 0;
  - bit 7 is the second-level kanji flag.
- R6: Addresses 0xC000–0xCFFF select console RAM at offset ((con_bank−1)<<12) + (addr−0xC000). This happens only while monitor RAM is in use and the console bank is 1 or 2.
- R7: The mode register is written through select 3. Its fields drive the outputs as follows:
  - bit 3 clear drives the 400-line output high;
  - bit 4 set drives the 256k-colour output high;
  - bit 2 clear turns write protect on;
  - bit 5 drives the kanji-sub output.
- R8: A write strobe raises the memory write enable for console RAM always. It raises it for character RAM and monitor RAM only while write protect is off. It never raises it for any ROM region or the unmapped region.
- R9: The system-select register is written through select 0, with bits 1:0 as the ROM bank request and bit 2 as the monitor-RAM request. These requests take effect only on a restart pulse. Until then the decode keeps the previous in-use values.
- R10: Addresses matching no region give the unmapped region. On such an address a read strobe raises the 0xFF fill flag and no memory enable.
- R11: The region output is one-hot, in this bit order:
  - bit 0: character ROM;
  - bit 1: character RAM;
  - bit 2: ROM C;
  - bit 3: ROM A;
  - bit 4: ROM B;
  - bit 5: monitor RAM;
  - bit 6: console RAM;
  - bit 7: unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_addr_i | input | 16 | Sub-processor address |
| cpu_rd_i | input | 1 | Read strobe |
| cpu_wr_i | input | 1 | Write strobe |
| ctl_we_i | input | 1 | Control register write |
| ctl_sel_i | input | 2 | Control register select (0 system, 1 char ROM bank, 2 bank, 3 mode) |
| ctl_data_i | input | 8 | Control register write data |
| restart_i | input | 1 | Sub-processor reset or release pulse |
| region_oh_o | output | 8 | One-hot region select |
| mem_ofs_o | output | 14 | Byte offset into the selected memory |
| mem_re_o | output | 1 | Memory read enable |
| mem_we_o | output | 1 | Memory write enable |
| fill_ff_o | output | 1 | Unmapped read, return 0xFF |
| line400_o | output | 1 | 400-line mode |
| color256k_o | output | 1 | 256k-colour mode |
| kanji_sub_o | output | 1 | Kanji-sub flag |
| kanji_lv2_o | output | 1 | Second-level kanji flag |
| wr_protect_o | output | 1 | RAM write protect active |

## Verification
The bench sweeps the address range around every region boundary under each control setting. It compares region and offset against arithmetic expectations, so it catches off-by-one edges at 0xD000, 0xD800 and 0xE000. It also catches the ROM C offset bug, where a decoder measures ROM C from 0xE000 instead of 0xD800.

The bench writes new bank and monitor requests and sweeps again before any restart. A decoder that applied the live registers instead of the in-use copies would remap at once and fail those checks.

The bench writes a console bank field of 3 and expects the console window to disappear. It toggles the protect bit, which is active low, while writing to character RAM and monitor RAM. A design with an inverted polarity would either drop writes that are legal or let through writes that are protected.

// File: rtl/smd_pkg.sv
package smd_pkg;
    localparam int DATA_W    = 8;
    localparam int SEL_W     = 2;
    localparam int ROMSEL_W  = 2;
    localparam int CROM_W    = 2;
    localparam int CRAM_W    = 3;
    localparam int CONBK_W   = 2;

    localparam logic [SEL_W-1:0] SEL_SYS  = 2'd0;
    localparam logic [SEL_W-1:0] SEL_CROM = 2'd1;
    localparam logic [SEL_W-1:0] SEL_BANK = 2'd2;
    localparam logic [SEL_W-1:0] SEL_MODE = 2'd3;

    typedef enum logic [2:0] {
        RG_CROM   = 3'd0,
        RG_CRAM   = 3'd1,
        RG_ROMC   = 3'd2,
        RG_ROMA   = 3'd3,
        RG_ROMB   = 3'd4,
        RG_MONRAM = 3'd5,
        RG_CONRAM = 3'd6,
        RG_NONE   = 3'd7
    } region_e;

    localparam int NREGION = 8;

    typedef struct packed {
        logic [ROMSEL_W-1:0] rom_req;
        logic                mon_req;
        logic [ROMSEL_W-1:0] rom_use;
        logic                mon_use;
        logic [CROM_W-1:0]   crom_bank;
        logic [CRAM_W-1:0]   cram_bank;
        logic [CONBK_W-1:0]  con_bank;
        logic                kanji_lv2;
        logic                line400;
        logic                color256k;
        logic                protect;
        logic                kanji_sub;
    } ctl_state_t;
endpackage

// File: rtl/smd_ctrl_regs.sv
module smd_ctrl_regs
    import smd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctl_we_i,
    input  logic [SEL_W-1:0]     ctl_sel_i,
    input  logic [DATA_W-1:0]    ctl_data_i,
    input  logic                 restart_i,
    output ctl_state_t           state_o
);
    localparam ctl_state_t RESET_STATE = '{
        rom_req:   '0,
        mon_req:   1'b0,
        rom_use:   '0,
        mon_use:   1'b0,
        crom_bank: '0,
        cram_bank: '0,
        con_bank:  '0,
        kanji_lv2: 1'b0,
        line400:   1'b0,
        color256k: 1'b0,
        protect:   1'b1,
        kanji_sub: 1'b0
    };
    localparam logic [CONBK_W-1:0] CON_MAX = CONBK_W'(2);

    ctl_state_t s_d, s_q;
    logic [CONBK_W-1:0] con_field;

    always_comb begin
        s_d       = s_q;
        con_field = ctl_data_i[4:3];
        if (ctl_we_i) begin
            case (ctl_sel_i)
                SEL_SYS: begin
                    s_d.rom_req = ctl_data_i[ROMSEL_W-1:0];
                    s_d.mon_req = ctl_data_i[2];
                end
                SEL_CROM: begin
                    s_d.crom_bank = ctl_data_i[CROM_W-1:0];
                end
                SEL_BANK: begin
                    s_d.cram_bank = ctl_data_i[CRAM_W-1:0];
                    s_d.con_bank  = (con_field > CON_MAX) ? '0 : con_field;
                    s_d.kanji_lv2 = ctl_data_i[7];
                end
                default: begin
                    s_d.line400   = ~ctl_data_i[3];
                    s_d.color256k = ctl_data_i[4];
                    s_d.protect   = ~ctl_data_i[2];
                    s_d.kanji_sub = ctl_data_i[5];
                end
            endcase
        end
        if (restart_i) begin
            s_d.rom_use = s_d.rom_req;
            s_d.mon_use = s_d.mon_req;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= RESET_STATE;
        else        s_q <= s_d;
    end

    assign state_o = s_q;

    AST_CON_BANK_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.con_bank != 2'd3); // R5
    AST_USE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !restart_i |=> $stable({s_q.rom_use, s_q.mon_use})); // R9
endmodule

// File: rtl/smd_addr_map.sv
module smd_addr_map
    import smd_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter int                OFS_W    = 14,
    parameter logic [ADDR_W-1:0] CON_BASE = 16'hC000,
    parameter logic [ADDR_W-1:0] CON_SPAN = 16'h1000,
    parameter logic [ADDR_W-1:0] CG_BASE  = 16'hD800,
    parameter logic [ADDR_W-1:0] HI_BASE  = 16'hE000,
    parameter int                CG_SH    = 11,
    parameter int                CON_SH   = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr_i,
    input  ctl_state_t          st_i,
    output region_e             region_o,
    output logic [OFS_W-1:0]    ofs_o
);
    localparam logic [ADDR_W-1:0] CON_END = CON_BASE + CON_SPAN;

    logic [ADDR_W-1:0] d_cg, d_hi, d_con;
    logic [OFS_W-1:0]  cram_page, crom_page, con_page;

    always_comb begin
        d_cg      = addr_i - CG_BASE;
        d_hi      = addr_i - HI_BASE;
        d_con     = addr_i - CON_BASE;
        cram_page = OFS_W'(st_i.cram_bank) << CG_SH;
        crom_page = OFS_W'(st_i.crom_bank) << CG_SH;
        con_page  = OFS_W'(st_i.con_bank - CONBK_W'(1)) << CON_SH;
        region_o  = RG_NONE;
        ofs_o     = '0;
        if (addr_i >= HI_BASE) begin
            if (st_i.mon_use) begin
                region_o = RG_MONRAM;
                ofs_o    = OFS_W'(d_hi);
            end else begin
                case (st_i.rom_use)
                    2'd0: begin region_o = RG_ROMC; ofs_o = OFS_W'(d_cg); end
                    2'd1: begin region_o = RG_ROMA; ofs_o = OFS_W'(d_hi); end
                    2'd2: begin region_o = RG_ROMB; ofs_o = OFS_W'(d_hi); end
                    default: begin region_o = RG_CROM; ofs_o = OFS_W'(d_hi); end
                endcase
            end
        end else if (addr_i >= CG_BASE) begin
            if (st_i.mon_use) begin
                region_o = RG_CRAM;
                ofs_o    = cram_page + OFS_W'(d_cg);
            end else begin
                region_o = RG_CROM;
                ofs_o    = crom_page + OFS_W'(d_cg);
            end
        end else if (addr_i >= CON_BASE && addr_i < CON_END
                     && st_i.mon_use && st_i.con_bank != '0) begin
            region_o = RG_CONRAM;
            ofs_o    = con_page + OFS_W'(d_con);
        end
    end

    AST_HI_ALWAYS_MAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i >= HI_BASE) |-> (region_o != RG_NONE && region_o != RG_CRAM
                                 && region_o != RG_CONRAM)); // R4
    AST_CON_NEEDS_MON: assert property (@(posedge clk) disable iff (!rst_n)
        (region_o == RG_CONRAM) |-> (st_i.mon_use && addr_i < CG_BASE)); // R6
endmodule

// File: rtl/subsys_mem_decoder.sv
module subsys_mem_decoder
    import smd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    cpu_addr_i,
    input  logic                 cpu_rd_i,
    input  logic                 cpu_wr_i,
    input  logic                 ctl_we_i,
    input  logic [1:0]           ctl_sel_i,
    input  logic [7:0]           ctl_data_i,
    input  logic                 restart_i,
    output logic [7:0]           region_oh_o,
    output logic [OFS_W-1:0]     mem_ofs_o,
    output logic                 mem_re_o,
    output logic                 mem_we_o,
    output logic                 fill_ff_o,
    output logic                 line400_o,
    output logic                 color256k_o,
    output logic                 kanji_sub_o,
    output logic                 kanji_lv2_o,
    output logic                 wr_protect_o
);
    ctl_state_t st;
    region_e    region;
    logic       writable;

    smd_ctrl_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_we_i   (ctl_we_i),
        .ctl_sel_i  (ctl_sel_i),
        .ctl_data_i (ctl_data_i),
        .restart_i  (restart_i),
        .state_o    (st)
    );

    smd_addr_map #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (cpu_addr_i),
        .st_i     (st),
        .region_o (region),
        .ofs_o    (mem_ofs_o)
    );

    always_comb begin
        region_oh_o = '0;
        region_oh_o[region] = 1'b1;
        case (region)
            RG_CONRAM:         writable = 1'b1;
            RG_CRAM, RG_MONRAM: writable = ~st.protect;
            default:           writable = 1'b0;
        endcase
        mem_re_o  = cpu_rd_i && region != RG_NONE;
        fill_ff_o = cpu_rd_i && region == RG_NONE;
        mem_we_o  = cpu_wr_i && writable;
    end

    assign line400_o    = st.line400;
    assign color256k_o  = st.color256k;
    assign kanji_sub_o  = st.kanji_sub;
    assign kanji_lv2_o  = st.kanji_lv2;
    assign wr_protect_o = st.protect;

    AST_REGION_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(region_oh_o)); // R11
    AST_WE_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && (region_oh_o[RG_CRAM] || region_oh_o[RG_MONRAM])) |-> !wr_protect_o); // R8
    AST_ROM_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (region_oh_o[RG_CROM] || region_oh_o[RG_ROMA] || region_oh_o[RG_ROMB]
         || region_oh_o[RG_ROMC]) |-> !mem_we_o); // R8
    AST_NONE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        region_oh_o[RG_NONE] |-> (!mem_re_o && !mem_we_o)); // R10
endmodule

// File: tb/tb_subsys_mem_decoder.sv
module tb_subsys_mem_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic        ctl_we = 1'b0;
    logic [1:0]  ctl_sel = 2'd0;
    logic [7:0]  ctl_data = 8'h00;
    logic        restart = 1'b0;
    logic [7:0]  region_oh;
    logic [13:0] mem_ofs;
    logic        mem_re, mem_we, fill_ff;
    logic        line400, color256k, kanji_sub, kanji_lv2, wr_protect;

    int n_checks = 0, n_fail = 0;

    // bench model of the control state
    int m_rom_req = 0, m_mon_req = 0, m_rom_use = 0, m_mon_use = 0;
    int m_crom = 0, m_cram = 0, m_con = 0;
    int m_protect = 1;

    always #5 clk = ~clk;

    subsys_mem_decoder dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr_i(cpu_addr), .cpu_rd_i(cpu_rd),
        .cpu_wr_i(cpu_wr), .ctl_we_i(ctl_we), .ctl_sel_i(ctl_sel),
        .ctl_data_i(ctl_data), .restart_i(restart), .region_oh_o(region_oh),
        .mem_ofs_o(mem_ofs), .mem_re_o(mem_re), .mem_we_o(mem_we),
        .fill_ff_o(fill_ff), .line400_o(line400), .color256k_o(color256k),
        .kanji_sub_o(kanji_sub), .kanji_lv2_o(kanji_lv2), .wr_protect_o(wr_protect)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        ctl_we = 1'b1; ctl_sel = sel; ctl_data = data;
        @(negedge clk);
        ctl_we = 1'b0;
        case (sel)
            2'd0: begin m_rom_req = data[1:0]; m_mon_req = data[2]; end
            2'd1: m_crom = data[1:0];
            2'd2: begin m_cram = data[2:0]; m_con = (data[4:3] == 2'd3) ? 0 : data[4:3]; end
            default: m_protect = data[2] ? 0 : 1;
        endcase
    endtask

    task automatic do_restart();
        @(negedge clk);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        m_rom_use = m_rom_req;
        m_mon_use = m_mon_req;
    endtask

    // expected region index and offset for an address, from the requirements
    task automatic expect_map(input int a, output int rg, output int ofs);
        rg = 7; ofs = 0;
        if (a >= 'hE000) begin
            if (m_mon_use != 0) begin rg = 5; ofs = a - 'hE000; end
            else case (m_rom_use)
                0: begin rg = 2; ofs = a - 'hD800; end
                1: begin rg = 3; ofs = a - 'hE000; end
                2: begin rg = 4; ofs = a - 'hE000; end
                default: begin rg = 0; ofs = a - 'hE000; end
            endcase
        end else if (a >= 'hD800) begin
            if (m_mon_use != 0) begin rg = 1; ofs = m_cram * 'h800 + (a - 'hD800); end
            else begin rg = 0; ofs = m_crom * 'h800 + (a - 'hD800); end
        end else if (a >= 'hC000 && a < 'hD000 && m_mon_use != 0 && m_con != 0) begin
            rg = 6; ofs = (m_con - 1) * 'h1000 + (a - 'hC000);
        end
    endtask

    task automatic check_addr(input string tag, input int a);
        int rg, ofs, we_exp;
        expect_map(a, rg, ofs);
        cpu_addr = a[15:0]; cpu_rd = 1'b1; cpu_wr = 1'b0;
        #1;
        chk({tag, " R11 region"}, int'(region_oh), 1 << rg);
        if (rg != 7) chk({tag, " offset"}, int'(mem_ofs), ofs);
        chk({tag, " R10 re/fill"}, {mem_re, fill_ff}, (rg == 7) ? 1 : 2);
        cpu_rd = 1'b0; cpu_wr = 1'b1;
        #1;
        we_exp = (rg == 6) || ((rg == 1 || rg == 5) && m_protect == 0);
        chk({tag, " R8 we"}, int'(mem_we), we_exp);
        cpu_wr = 1'b0;
    endtask

    task automatic sweep(input string tag);
        int edges[10] = '{'h0000, 'hBFFF, 'hC000, 'hCFFF, 'hD000, 'hD7FF,
                          'hD800, 'hDFFF, 'hE000, 'hFFFF};
        foreach (edges[i]) check_addr(tag, edges[i]);
        for (int a = 'hBF00; a <= 'hFFFF; a += 13) check_addr(tag, a);
    endtask

    task automatic check_mode(input string tag, input int l4, input int c256,
                              input int ks, input int kl2);
        chk({tag, " line400"}, int'(line400), l4);
        chk({tag, " color256k"}, int'(color256k), c256);
        chk({tag, " kanji_sub"}, int'(kanji_sub), ks);
        chk({tag, " kanji_lv2"}, int'(kanji_lv2), kl2);
        chk({tag, " protect"}, int'(wr_protect), m_protect);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_mode("R1 reset", 0, 0, 0, 0);
        sweep("R1");
        // R2 char ROM bank
        wr_reg(2'd1, 8'h02);
        sweep("R2 crom2");
        wr_reg(2'd1, 8'h03);
        sweep("R2 crom3");
        // R9 request pending, R4 after restart
        for (int b = 1; b < 4; b++) begin
            wr_reg(2'd0, 8'(b));
            sweep("R9 pending");
            do_restart();
            sweep("R4 bank");
        end
        // R7 mode register
        wr_reg(2'd3, 8'h00);
        check_mode("R7 m00", 1, 0, 0, 0);
        wr_reg(2'd3, 8'h34);
        check_mode("R7 m34", 1, 1, 1, 0);
        wr_reg(2'd3, 8'h08);
        check_mode("R7 m08", 0, 0, 0, 0);
        // R5 bank register, R3/R6 with monitor in use
        wr_reg(2'd2, 8'h8D);
        check_mode("R5 lv2", 0, 0, 0, 1);
        wr_reg(2'd0, 8'h04);
        sweep("R9 mon pending");
        do_restart();
        sweep("R3 R6 protect on");
        wr_reg(2'd3, 8'h0C);
        sweep("R8 protect off");
        wr_reg(2'd2, 8'h13);
        check_mode("R5 lv2 clear", 0, 0, 0, 0);
        sweep("R6 con2");
        wr_reg(2'd2, 8'h1E);
        sweep("R5 con3 forced 0");
        // release monitor: pending until restart
        wr_reg(2'd0, 8'h01);
        sweep("R9 release pending");
        do_restart();
        sweep("R10 R4 after release");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule